// File: doc/BRIEF.md
# Digital Memristor Emulator Core

This block is the digital update engine of a memristor emulator. An external converter delivers voltage samples as an 8-bit magnitude with a separate sign bit, qualified by a valid strobe. The core integrates each sample into an unsigned state register that stands for the doped-region length. It then maps that state linearly onto a resistance lying between a programmable low bound and a programmable high bound. The upper byte of that resistance goes to a digital potentiometer as a code, together with a one-cycle update strobe.

The integration saturates. Once the state reaches either end, further samples of the same polarity leave it there, and the first sample of opposite polarity moves it back at once. A sample of zero magnitude, or a clock cycle with no sample, leaves the state untouched, so the last resistance is held indefinitely. A synchronous reset loads a state that corresponds to a programmable initial resistance. A parameter chooses whether positive input lowers or raises the resistance.

Top module: `memr_emu_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the state loads x0 = floor((r_off − ri)·65535 / (r_off − r_on)), where ri is `r_init` clamped into [r_on, r_off]. x0 is 0 when r_off equals r_on. After such an edge, `pot_strobe` is 0 and `pot_code` is the code that R2 gives for x0.
- R2: For a state x in [0, 65535], the resistance is R = r_off − floor((r_off − r_on)·x / 65535). `pot_code` is R[15:8].
- R3: With the default polarity, a valid sample with `smp_sign` = 0 (positive) raises x by `smp_mag`·`gain`, which lowers R. A valid sample with `smp_sign` = 1 (negative) lowers x by the same amount.
- R4: The state saturates at 65535 when moving up and at 0 when moving down. It never wraps around.
- R5: At either bound, further samples of the same sign leave `pot_code` unchanged. The first sample of the opposite sign with a non-zero step moves it off the bound.
- R6: A valid sample with `smp_mag` = 0 leaves the state, and therefore `pot_code`, unchanged.
- R7: `pot_strobe` is 1 in exactly the cycle after each cycle in which `smp_valid` was 1, and 0 otherwise. `pot_code` changes only together with a strobe or a reset.
- R8: `pot_code` always lies between r_on[15:8] and r_off[15:8], and reaches each of these values at the matching state bound.
- R9: With POS_LOWERS = 0, the direction is reversed: a positive sample lowers x and a negative sample raises it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads the initial state |
| smp_valid | input | 1 | Sample qualifier |
| smp_sign | input | 1 | Sample sign, 1 = negative |
| smp_mag | input | 8 | Sample magnitude |
| gain | input | 8 | Per-sample step multiplier |
| r_on | input | 16 | Low resistance bound |
| r_off | input | 16 | High resistance bound |
| r_init | input | 16 | Resistance loaded at reset |
| pot_code | output | 8 | Potentiometer code |
| pot_strobe | output | 1 | One-cycle pulse marking a new code |

## Verification
Every result is due one clock after its cause. A sample presented before a rising edge changes `pot_code` and raises `pot_strobe` at that same edge, and a reset edge loads the initial code at that edge. The bench therefore drives each stimulus at a falling edge, lets a single rising edge pass, advances its behavioural model, and compares both outputs at the next falling edge. It does this for two instances built with opposite polarity settings. Idle cycles and zero-magnitude samples are compared in the same way, which shows at the ports that the code was held.

// File: rtl/memr_emu_pkg.sv
package memr_emu_pkg;
   typedef enum logic {DIR_DOWN = 1'b0, DIR_UP = 1'b1} dir_e;
endpackage

// File: rtl/memr_init_calc.sv
module memr_init_calc #(
   parameter int STATE_W = 16,
   parameter int RES_W   = 16
) (
   input  logic [RES_W-1:0]   r_on,
   input  logic [RES_W-1:0]   r_off,
   input  logic [RES_W-1:0]   r_init,
   output logic [STATE_W-1:0] init_state
);
   localparam int PROD_W = RES_W + STATE_W;
   localparam logic [PROD_W-1:0] XMAX_P = PROD_W'({STATE_W{1'b1}});

   logic [RES_W-1:0]  ri_clamped;
   logic [RES_W-1:0]  span;
   logic [PROD_W-1:0] numer;
   logic [PROD_W-1:0] quot;

   always_comb begin
      span = (r_off >= r_on) ? (r_off - r_on) : '0;
      if (r_init < r_on)       ri_clamped = r_on;
      else if (r_init > r_off) ri_clamped = r_off;
      else                     ri_clamped = r_init;
      numer = PROD_W'(r_off - ri_clamped) * XMAX_P;
      quot  = (span == '0) ? '0 : numer / PROD_W'(span);
      // quot never exceeds XMAX because ri_clamped >= r_on
      init_state = (quot > XMAX_P) ? '1 : quot[STATE_W-1:0];
   end
endmodule

// File: rtl/memr_res_map.sv
module memr_res_map #(
   parameter int STATE_W = 16,
   parameter int RES_W   = 16
) (
   input  logic [RES_W-1:0]   r_on,
   input  logic [RES_W-1:0]   r_off,
   input  logic [STATE_W-1:0] state,
   output logic [RES_W-1:0]   res
);
   localparam int PROD_W = RES_W + STATE_W;
   localparam logic [PROD_W-1:0] XMAX_P = PROD_W'({STATE_W{1'b1}});

   logic [RES_W-1:0]  span;
   logic [PROD_W-1:0] scaled;
   logic [PROD_W-1:0] drop;

   always_comb begin
      span   = (r_off >= r_on) ? (r_off - r_on) : '0;
      scaled = PROD_W'(span) * PROD_W'(state);
      drop   = scaled / XMAX_P;
      res    = r_off - RES_W'(drop);
   end
endmodule

// File: rtl/memr_state_int.sv
module memr_state_int
   import memr_emu_pkg::*;
#(
   parameter int MAG_W      = 8,
   parameter int GAIN_W     = 8,
   parameter int STATE_W    = 16,
   parameter bit POS_LOWERS = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STATE_W-1:0] init_state,
   input  logic               smp_valid,
   input  logic               smp_sign,
   input  logic [MAG_W-1:0]   smp_mag,
   input  logic [GAIN_W-1:0]  gain,
   output logic [STATE_W-1:0] state_next
);
   localparam int PROD_W = MAG_W + GAIN_W;
   localparam int SUM_W  = ((PROD_W > STATE_W) ? PROD_W : STATE_W) + 1;
   localparam logic [SUM_W-1:0]   XMAX_EXT = SUM_W'({STATE_W{1'b1}});
   localparam logic [STATE_W-1:0] XMAX     = '1;

   logic [STATE_W-1:0] state_q;
   logic [PROD_W-1:0]  step_amt;
   logic [SUM_W-1:0]   st_ext, amt_ext, up_sum;
   logic [STATE_W-1:0] up_val, dn_val;
   dir_e               dir;

   generate
      if (POS_LOWERS) begin : g_pos_up
         assign dir = smp_sign ? DIR_DOWN : DIR_UP;
      end else begin : g_pos_down
         assign dir = smp_sign ? DIR_UP : DIR_DOWN;
      end
   endgenerate

   always_comb begin
      step_amt = PROD_W'(smp_mag) * PROD_W'(gain);
      st_ext   = SUM_W'(state_q);
      amt_ext  = SUM_W'(step_amt);
      up_sum   = st_ext + amt_ext;
      up_val   = (up_sum > XMAX_EXT) ? XMAX : (state_q + STATE_W'(step_amt));
      dn_val   = (amt_ext >= st_ext) ? '0 : (state_q - STATE_W'(step_amt));
      if (!rst_n)                          state_next = init_state;
      else if (smp_valid && dir == DIR_UP) state_next = up_val;
      else if (smp_valid)                  state_next = dn_val;
      else                                 state_next = state_q;
   end

   always_ff @(posedge clk) state_q <= state_next;

   assert_sat_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == XMAX && smp_valid && dir == DIR_UP) |=> state_q == XMAX);
   assert_sat_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == '0 && smp_valid && dir == DIR_DOWN) |=> state_q == '0);
   assert_move_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && dir == DIR_UP && state_q != XMAX && smp_mag != '0 && gain != '0)
      |=> state_q > $past(state_q));
   assert_move_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_valid && dir == DIR_DOWN && state_q != '0 && smp_mag != '0 && gain != '0)
      |=> state_q < $past(state_q));
   assert_zero_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_n && (!smp_valid || smp_mag == '0)) |=> $stable(state_q));
endmodule

// File: rtl/memr_emu_core.sv
module memr_emu_core #(
   parameter int MAG_W      = 8,
   parameter int GAIN_W     = 8,
   parameter int STATE_W    = 16,
   parameter int RES_W      = 16,
   parameter int CODE_W     = 8,
   parameter bit POS_LOWERS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   input  logic              smp_sign,
   input  logic [MAG_W-1:0]  smp_mag,
   input  logic [GAIN_W-1:0] gain,
   input  logic [RES_W-1:0]  r_on,
   input  logic [RES_W-1:0]  r_off,
   input  logic [RES_W-1:0]  r_init,
   output logic [CODE_W-1:0] pot_code,
   output logic              pot_strobe
);
   localparam int LO_W = RES_W - CODE_W;

   generate
      if (CODE_W > RES_W || CODE_W < 1) begin : g_bad_code_w
         $error("memr_emu_core: CODE_W must lie in 1..RES_W");
      end
      if (STATE_W < 2 || MAG_W < 1 || GAIN_W < 1) begin : g_bad_widths
         $error("memr_emu_core: STATE_W, MAG_W and GAIN_W too small");
      end
   endgenerate

   logic [STATE_W-1:0] x_init, x_next;
   logic [RES_W-1:0]   r_next;
   logic [CODE_W-1:0]  code_next;

   memr_init_calc #(.STATE_W(STATE_W), .RES_W(RES_W)) u_init (
      .r_on(r_on), .r_off(r_off), .r_init(r_init), .init_state(x_init));

   memr_state_int #(.MAG_W(MAG_W), .GAIN_W(GAIN_W), .STATE_W(STATE_W),
                    .POS_LOWERS(POS_LOWERS)) u_int (
      .clk(clk), .rst_n(rst_n), .init_state(x_init), .smp_valid(smp_valid),
      .smp_sign(smp_sign), .smp_mag(smp_mag), .gain(gain), .state_next(x_next));

   memr_res_map #(.STATE_W(STATE_W), .RES_W(RES_W)) u_map (
      .r_on(r_on), .r_off(r_off), .state(x_next), .res(r_next));

   assign code_next = r_next[RES_W-1 -: CODE_W];

   generate
      if (LO_W > 0) begin : g_lo
         logic unused_lo_bits;
         assign unused_lo_bits = ^r_next[LO_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pot_code   <= code_next;
         pot_strobe <= 1'b0;
      end else begin
         pot_strobe <= smp_valid;
         if (smp_valid) pot_code <= code_next;
      end
   end

   assert_code_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !pot_strobe) |-> $stable(pot_code));
   assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && r_on <= r_off) |->
      (pot_code >= r_on[RES_W-1 -: CODE_W] && pot_code <= r_off[RES_W-1 -: CODE_W]));
endmodule

// File: tb/memr_emu_core_test.sv
module memr_emu_core_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       smp_valid = 1'b0;
   logic       smp_sign = 1'b0;
   logic [7:0] smp_mag = '0;
   logic [7:0] gain = 8'd16;
   logic [15:0] r_on = 16'h1000, r_off = 16'hF000, r_init = 16'h8000;
   logic [7:0] code_a, code_b;
   logic       stb_a, stb_b;

   int  n_checks = 0, n_fails = 0;
   bit  done = 1'b0;
   longint xa, xb;

   always #10 clk = ~clk;

   memr_emu_core uut (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sign(smp_sign),
      .smp_mag(smp_mag), .gain(gain), .r_on(r_on), .r_off(r_off), .r_init(r_init),
      .pot_code(code_a), .pot_strobe(stb_a));

   memr_emu_core #(.POS_LOWERS(1'b0)) uut_inv (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_sign(smp_sign),
      .smp_mag(smp_mag), .gain(gain), .r_on(r_on), .r_off(r_off), .r_init(r_init),
      .pot_code(code_b), .pot_strobe(stb_b));

   function automatic longint span_of();
      return (r_off >= r_on) ? longint'(r_off) - longint'(r_on) : 0;
   endfunction

   function automatic longint code_of(longint x);
      longint r;
      r = longint'(r_off) - (span_of() * x) / 65535;
      return (r >> 8) & 255;
   endfunction

   function automatic longint init_of();
      longint ri;
      ri = r_init;
      if (ri < r_on) ri = r_on;
      if (ri > r_off) ri = r_off;
      if (span_of() == 0) return 0;
      return ((longint'(r_off) - ri) * 65535) / span_of();
   endfunction

   function automatic longint next_x(longint x, bit up);
      longint s;
      s = longint'(smp_mag) * longint'(gain);
      if (up) return (x + s > 65535) ? 65535 : x + s;
      return (s >= x) ? 0 : x - s;
   endfunction

   task automatic check(string tag, longint got, longint exp);
      n_checks++;
      if (got != exp) begin
         n_fails++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic outs(string tag, bit exp_stb);
      check({tag, " strobe"}, longint'(stb_a), longint'(exp_stb));
      check({tag, " code"}, longint'(code_a), code_of(xa));
      check({tag, " R9 strobe"}, longint'(stb_b), longint'(exp_stb));
      check({tag, " R9 code"}, longint'(code_b), code_of(xb));
      check("R8 range", longint'(code_a >= r_on[15:8] && code_a <= r_off[15:8]), 1);
   endtask

   task automatic step(string tag, bit v, bit sgn, logic [7:0] mag);
      smp_valid = v; smp_sign = sgn; smp_mag = mag;
      @(posedge clk);
      if (v) begin
         xa = next_x(xa, !sgn);
         xb = next_x(xb, sgn);
      end
      @(negedge clk);
      smp_valid = 1'b0;
      outs(tag, v);
   endtask

   task automatic do_reset(string tag);
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      xa = init_of(); xb = xa;
      @(negedge clk);
      outs(tag, 1'b0);
      rst_n = 1'b1;
   endtask

   initial begin
      @(negedge clk);
      do_reset("R1 reset mid");
      check("R1 initial code", longint'(code_a), 128);
      step("R3 pos small", 1, 0, 8'd100);
      step("R3 pos small", 1, 0, 8'd100);
      step("R3 neg small", 1, 1, 8'd37);
      step("R7 idle", 0, 0, 8'd200);
      step("R7 idle", 0, 1, 8'd5);
      step("R6 zero mag", 1, 0, 8'd0);
      step("R6 zero mag", 1, 1, 8'd0);
      gain = 8'd255;
      step("R2 big pos", 1, 0, 8'd90);
      step("R4 sat high", 1, 0, 8'd255);
      step("R4 sat high", 1, 0, 8'd255);
      check("R8 code at Ron", longint'(code_a), 16);
      check("R8 inverted at Roff", longint'(code_b), 240);
      step("R5 hold same sign", 1, 0, 8'd1);
      step("R5 reversal", 1, 1, 8'd1);
      check("R5 moved off bound", longint'(code_a != 8'd16 || xa != 65535), 1);
      gain = 8'd3;
      for (int i = 0; i < 6; i++) step("R3 neg ramp", 1, 1, 8'(40 + i * 7));
      r_init = 16'hFFFF;
      do_reset("R1 reset clamped");
      check("R1 clamp to Roff", longint'(code_a), 240);
      step("R5 hold at zero", 1, 1, 8'd50);
      step("R5 reversal from zero", 1, 0, 8'd50);
      r_init = 16'h0000;
      do_reset("R1 reset clamped low");
      check("R1 clamp to Ron", longint'(code_a), 16);
      gain = 8'd200;
      for (int i = 0; i < 8; i++) step("R4 sat low", 1, 1, 8'd255);
      check("R8 code at Roff", longint'(code_a), 240);
      step("R7 idle after sat", 0, 0, 8'd0);
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   end
endmodule